// File: doc/BRIEF.md
# Masked Packed-Width Vector Lane ALU

This block is the integer datapath of one 64-bit vector lane. Each cycle it applies one operation to a lane word. A width code chosen at run time splits the word into four 16-bit elements, two 32-bit elements or one 64-bit element. Carries stop at element edges, so packed elements never disturb one another. Operands come from two vector words. Either side can instead take a scalar value, which is copied into every element position.

A per-element flag mask decides which elements are written back. The block drives one write strobe per 16-bit slot and zeroes the result bits of disabled elements. Each element also reports a one-bit exception flag, which means signed overflow for plain add and subtract, and clamping for the saturating adds. All outputs are registered, and a valid strobe marks each result word.

Top module: `vlane_alu`

## Requirements
- R1: After reset, and before any valid input is taken, `out_valid`, `out_result`, `out_wren` and `out_flags` are all zero.
- R2: `out_valid` equals `in_valid` from one clock earlier. A cycle with `in_valid` low produces a following cycle in which result, write strobes and flags are all zero.
- R3: `in_wcode` 0 selects four 16-bit elements, 1 selects two 32-bit elements, and 2 or 3 select one 64-bit element. No carry or borrow crosses an element edge.
- R4: Opcode 0 adds and opcode 1 subtracts (first operand minus second), both modulo the element width.
- R5: For opcodes 0 and 1, an element's flag is 1 exactly when its two's-complement result overflows the element width.
- R6: Opcode 2 is a signed saturating add. An overflowing element is clamped to the signed maximum or minimum of its width, and its flag is set.
- R7: Opcode 3 is an unsigned saturating add. An element whose sum exceeds the width's all-ones value becomes all ones, and its flag is set.
- R8: Opcodes 4, 5 and 6 give bitwise AND, OR and XOR with flags 0. Opcode 7 gives a zero result with flags 0.
- R9: `in_form` 0 (and 3) takes both operands from `in_a` and `in_b`. Form 1 replaces the second operand with the scalar. Form 2 replaces the first operand with the scalar. The scalar used is the low element-width bits of `in_scalar`, copied into every element.
- R10: An element is enabled by the mask bit of its lowest 16-bit slot, and mask bits of higher slots inside a wider element are ignored. Every `out_wren` slot of an element equals that bit. A disabled element has result bits 0 and flag 0.
- R11: An element's flag is reported at the `out_flags` bit of its lowest 16-bit slot. The other bits of that element are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request this cycle |
| in_wcode | input | 2 | Element width code |
| in_op | input | 3 | Opcode |
| in_form | input | 2 | Operand form (vector/vector, vector/scalar, scalar/vector) |
| in_a | input | 64 | First vector operand |
| in_b | input | 64 | Second vector operand |
| in_scalar | input | 64 | Scalar operand, low element used |
| in_mask | input | 4 | Flag mask, one bit per 16-bit slot |
| out_valid | output | 1 | Result word valid |
| out_result | output | 64 | Packed result |
| out_wren | output | 4 | Write strobe per 16-bit slot |
| out_flags | output | 4 | Exception flag per element, at its lowest slot |

## Verification
Every result is due exactly one clock after the cycle in which its inputs were presented. The same holds for the write strobes, the exception flags and the valid strobe. There is no other latency. The bench drives inputs on the falling edge and pushes the expected outputs into a queue at that moment. On the next falling edge, one register stage later, it pops the entry and compares it with all four outputs together. Idle cycles enqueue an all-zero expectation, so the quiet output after a gap is checked in the same slot.

// File: rtl/vlane_pkg.sv
package vlane_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_SADDS = 3'd2,
    OP_UADDS = 3'd3,
    OP_AND   = 3'd4,
    OP_OR    = 3'd5,
    OP_XOR   = 3'd6,
    OP_NONE  = 3'd7
  } vop_e;

  typedef enum logic [1:0] {
    SRC_VV  = 2'd0,
    SRC_VS  = 2'd1,
    SRC_SV  = 2'd2,
    SRC_VV2 = 2'd3
  } vsrc_e;

  // Number of 16-bit slots one element spans for a width code.
  function automatic int unsigned span_segs(input logic [1:0] wcode,
                                            input int unsigned nseg);
    int unsigned s;
    s = 1 << wcode;
    if (s > nseg) s = nseg;
    return s;
  endfunction

  // Lowest slot of the element that contains slot seg.
  function automatic int unsigned lead_seg(input int unsigned seg,
                                           input int unsigned span);
    return seg - (seg % span);
  endfunction

endpackage

// File: rtl/vlane_operand.sv
module vlane_operand
  import vlane_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int NSEG  = 4
) (
  input  logic [1:0]              form,
  input  logic [1:0]              wcode,
  input  logic [SEG_W*NSEG-1:0]   src_a,
  input  logic [SEG_W*NSEG-1:0]   src_b,
  input  logic [SEG_W*NSEG-1:0]   scalar,
  output logic [SEG_W*NSEG-1:0]   opa,
  output logic [SEG_W*NSEG-1:0]   opb
);
  localparam int LANE_W = SEG_W * NSEG;

  logic [LANE_W-1:0] bcast;
  int unsigned       span;

  // Copy the low element of the scalar into every element position.
  always_comb begin
    span = span_segs(wcode, NSEG);
    for (int i = 0; i < NSEG; i++) begin
      bcast[i*SEG_W +: SEG_W] = scalar[(i % span)*SEG_W +: SEG_W];
    end
  end

  always_comb begin
    opa = src_a;
    opb = src_b;
    case (vsrc_e'(form))
      SRC_VS:  opb = bcast;
      SRC_SV:  opa = bcast;
      default: ;
    endcase
  end

endmodule

// File: rtl/vlane_seg.sv
module vlane_seg #(
  parameter int SEG_W = 16
) (
  input  logic [SEG_W-1:0] a,
  input  logic [SEG_W-1:0] b,
  input  logic             sub,
  input  logic             cin,
  output logic [SEG_W-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  logic [SEG_W-1:0] b_eff;

  function automatic logic [SEG_W:0] seg_add(input logic [SEG_W-1:0] x,
                                             input logic [SEG_W-1:0] y,
                                             input logic             c);
    return {1'b0, x} + {1'b0, y} + {{SEG_W{1'b0}}, c};
  endfunction

  always_comb begin
    b_eff       = sub ? ~b : b;
    {cout, sum} = seg_add(a, b_eff, cin);
    // Signed overflow as seen when this slot holds an element's sign bit.
    ovf = (a[SEG_W-1] == b_eff[SEG_W-1]) && (sum[SEG_W-1] != a[SEG_W-1]);
  end

endmodule

// File: rtl/vlane_post.sv
module vlane_post
  import vlane_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic [2:0]       op,
  input  logic [SEG_W-1:0] a,
  input  logic [SEG_W-1:0] b,
  input  logic [SEG_W-1:0] sum,
  input  logic             is_top,
  input  logic             e_ovf,
  input  logic             e_cout,
  input  logic             e_neg,
  input  logic             en,
  output logic [SEG_W-1:0] val,
  output logic             clamp,
  output logic             eflag
);
  logic [SEG_W-1:0] raw;
  logic             clamp_raw;
  logic             eflag_raw;

  // Slice of the signed limit: the top slot carries the sign bit.
  function automatic logic [SEG_W-1:0] sat_fill(input logic neg, input logic top);
    if (neg) return top ? {1'b1, {(SEG_W-1){1'b0}}} : {SEG_W{1'b0}};
    else     return top ? {1'b0, {(SEG_W-1){1'b1}}} : {SEG_W{1'b1}};
  endfunction

  always_comb begin
    raw       = '0;
    clamp_raw = 1'b0;
    eflag_raw = 1'b0;
    case (vop_e'(op))
      OP_ADD, OP_SUB: begin
        raw       = sum;
        eflag_raw = e_ovf;
      end
      OP_SADDS: begin
        raw       = e_ovf ? sat_fill(e_neg, is_top) : sum;
        clamp_raw = e_ovf;
        eflag_raw = e_ovf;
      end
      OP_UADDS: begin
        raw       = e_cout ? {SEG_W{1'b1}} : sum;
        clamp_raw = e_cout;
        eflag_raw = e_cout;
      end
      OP_AND:  raw = a & b;
      OP_OR:   raw = a | b;
      OP_XOR:  raw = a ^ b;
      default: raw = '0;
    endcase
    val   = en ? raw : '0;
    clamp = en & clamp_raw;
    eflag = en & eflag_raw;
  end

endmodule

// File: rtl/vlane_alu.sv
module vlane_alu
  import vlane_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int NSEG  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              in_wcode,
  input  logic [2:0]              in_op,
  input  logic [1:0]              in_form,
  input  logic [SEG_W*NSEG-1:0]   in_a,
  input  logic [SEG_W*NSEG-1:0]   in_b,
  input  logic [SEG_W*NSEG-1:0]   in_scalar,
  input  logic [NSEG-1:0]         in_mask,
  output logic                    out_valid,
  output logic [SEG_W*NSEG-1:0]   out_result,
  output logic [NSEG-1:0]         out_wren,
  output logic [NSEG-1:0]         out_flags
);
  localparam int LANE_W = SEG_W * NSEG;

  logic [LANE_W-1:0] opa, opb;
  logic              do_sub;
  int unsigned       span;

  logic [NSEG-1:0]   seg_lead, seg_top, seg_en;
  logic [NSEG-1:0]   seg_cin, seg_cout, seg_ovf;
  logic [NSEG-1:0]   top_ovf, top_cout, top_neg;
  logic [SEG_W-1:0]  seg_sum [NSEG];
  logic [SEG_W-1:0]  seg_val [NSEG];
  logic [NSEG-1:0]   seg_eflag;

  // Named events for the checker.
  logic [NSEG-1:0]   clamp_evt;
  logic [LANE_W-1:0] res_nxt;
  logic [NSEG-1:0]   flag_nxt;

  vlane_operand #(.SEG_W(SEG_W), .NSEG(NSEG)) u_opnd (
    .form   (in_form),
    .wcode  (in_wcode),
    .src_a  (in_a),
    .src_b  (in_b),
    .scalar (in_scalar),
    .opa    (opa),
    .opb    (opb)
  );

  assign do_sub = (vop_e'(in_op) == OP_SUB);

  // Element geometry per slot for the current width code.
  always_comb begin
    span = span_segs(in_wcode, NSEG);
    for (int i = 0; i < NSEG; i++) begin
      seg_lead[i] = (lead_seg(i, span) == i);
      seg_top[i]  = ((i % span) == span - 1);
      seg_en[i]   = in_mask[lead_seg(i, span)];
    end
  end

  generate
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
      if (g == 0) begin : g_first
        assign seg_cin[g] = do_sub;
      end else begin : g_rest
        // Break the carry chain at every element edge.
        assign seg_cin[g] = seg_lead[g] ? do_sub : seg_cout[g-1];
      end

      vlane_seg #(.SEG_W(SEG_W)) u_seg (
        .a    (opa[g*SEG_W +: SEG_W]),
        .b    (opb[g*SEG_W +: SEG_W]),
        .sub  (do_sub),
        .cin  (seg_cin[g]),
        .sum  (seg_sum[g]),
        .cout (seg_cout[g]),
        .ovf  (seg_ovf[g])
      );
    end
  endgenerate

  // Element-wide status taken from each element's top slot.
  always_comb begin
    int unsigned t;
    for (int i = 0; i < NSEG; i++) begin
      t           = lead_seg(i, span) + span - 1;
      top_ovf[i]  = seg_ovf[t];
      top_cout[i] = seg_cout[t];
      top_neg[i]  = opa[t*SEG_W + SEG_W - 1];
    end
  end

  generate
    for (genvar g = 0; g < NSEG; g++) begin : g_post
      vlane_post #(.SEG_W(SEG_W)) u_post (
        .op     (in_op),
        .a      (opa[g*SEG_W +: SEG_W]),
        .b      (opb[g*SEG_W +: SEG_W]),
        .sum    (seg_sum[g]),
        .is_top (seg_top[g]),
        .e_ovf  (top_ovf[g]),
        .e_cout (top_cout[g]),
        .e_neg  (top_neg[g]),
        .en     (seg_en[g]),
        .val    (seg_val[g]),
        .clamp  (clamp_evt[g]),
        .eflag  (seg_eflag[g])
      );
      assign res_nxt[g*SEG_W +: SEG_W] = seg_val[g];
      assign flag_nxt[g]               = seg_lead[g] & seg_eflag[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wren   <= '0;
      out_flags  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= res_nxt;
        out_wren   <= seg_en;
        out_flags  <= flag_nxt;
      end else begin
        out_result <= '0;
        out_wren   <= '0;
        out_flags  <= '0;
      end
    end
  end

endmodule

// File: rtl/vlane_alu_chk.sv
module vlane_alu_chk #(
  parameter int SEG_W = 16,
  parameter int NSEG  = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [1:0]            in_wcode,
  input logic [2:0]            in_op,
  input logic [NSEG-1:0]       in_mask,
  input logic [NSEG-1:0]       clamp_evt,
  input logic                  out_valid,
  input logic [SEG_W*NSEG-1:0] out_result,
  input logic [NSEG-1:0]       out_wren,
  input logic [NSEG-1:0]       out_flags
);
  function automatic logic [NSEG-1:0] odd_slots();
    logic [NSEG-1:0] m;
    for (int i = 0; i < NSEG; i++) m[i] = (i % 2 == 1);
    return m;
  endfunction

  localparam logic [NSEG-1:0] ODD = odd_slots();

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_valid_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (out_valid == $past(in_valid)));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_wren == '0 && out_flags == '0 && out_result == '0));

  p_we_narrow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_wcode) == 2'd0) |-> (out_wren == $past(in_mask)));

  p_we_wide_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_wcode) >= 2'd2) |-> (out_wren == {NSEG{$past(in_mask[0])}}));

  p_masked_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_wren[0]) |-> (out_result[SEG_W-1:0] == '0 && !out_flags[0]));

  p_flag_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_wcode) == 2'd1) |-> ((out_flags & ODD) == '0));

  p_logic_noflag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_op) >= 3'd4) |-> (out_flags == '0));

  p_clamp_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && |clamp_evt) |=> (|out_flags));

  p_usat_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_op) == 3'd3 && $past(in_wcode) == 2'd0 && out_flags[0])
      |-> (out_result[SEG_W-1:0] == {SEG_W{1'b1}}));

endmodule

bind vlane_alu vlane_alu_chk #(.SEG_W(SEG_W), .NSEG(NSEG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_wcode   (in_wcode),
  .in_op      (in_op),
  .in_mask    (in_mask),
  .clamp_evt  (clamp_evt),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_wren   (out_wren),
  .out_flags  (out_flags)
);

// File: tb/test_vlane_alu.sv
`timescale 1ns/1ps
module test_vlane_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_wcode = '0;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_form = '0;
  logic [63:0] in_a = '0, in_b = '0, in_scalar = '0;
  logic [3:0]  in_mask = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic [3:0]  out_wren, out_flags;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  typedef struct {
    logic        v;
    logic [63:0] r;
    logic [3:0]  we;
    logic [3:0]  fl;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  vlane_alu i_vlane_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wcode(in_wcode),
    .in_op(in_op), .in_form(in_form), .in_a(in_a), .in_b(in_b),
    .in_scalar(in_scalar), .in_mask(in_mask), .out_valid(out_valid),
    .out_result(out_result), .out_wren(out_wren), .out_flags(out_flags)
  );

  // Behavioural model, element by element with wide integers.
  function automatic void model(input logic [1:0] w, input logic [2:0] op,
                                input logic [1:0] fm, input logic [63:0] a,
                                input logic [63:0] b, input logic [63:0] s,
                                input logic [3:0] m, output logic [63:0] r,
                                output logic [3:0] we, output logic [3:0] fl);
    int sps, ew, ne;
    sps = (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
    ew  = 16 * sps;
    ne  = 4 / sps;
    r = '0; we = '0; fl = '0;
    for (int e = 0; e < ne; e++) begin
      logic [63:0] lim, x, y, z;
      logic signed [66:0] sx, sy, sz, smax, smin;
      logic [66:0] uz;
      logic f, en;
      lim = (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
      x = (a >> (e * ew)) & lim;
      y = (b >> (e * ew)) & lim;
      if (fm == 2'd1) y = s & lim;
      if (fm == 2'd2) x = s & lim;
      sx = $signed({3'b0, x}); if (x[ew-1]) sx = sx - (67'sd1 <<< ew);
      sy = $signed({3'b0, y}); if (y[ew-1]) sy = sy - (67'sd1 <<< ew);
      smax = (67'sd1 <<< (ew - 1)) - 67'sd1;
      smin = -(67'sd1 <<< (ew - 1));
      f = 1'b0; z = '0;
      case (op)
        3'd0: begin sz = sx + sy; f = (sz > smax) || (sz < smin); z = (x + y) & lim; end
        3'd1: begin sz = sx - sy; f = (sz > smax) || (sz < smin); z = (x - y) & lim; end
        3'd2: begin
          sz = sx + sy;
          if (sz > smax)      begin z = smax[63:0] & lim; f = 1'b1; end
          else if (sz < smin) begin z = smin[63:0] & lim; f = 1'b1; end
          else                z = sz[63:0] & lim;
        end
        3'd3: begin
          uz = {3'b0, x} + {3'b0, y};
          if (uz > {3'b0, lim}) begin z = lim; f = 1'b1; end
          else z = uz[63:0];
        end
        3'd4: z = x & y;
        3'd5: z = x | y;
        3'd6: z = x ^ y;
        default: z = '0;
      endcase
      en = m[e * sps];
      for (int k = 0; k < sps; k++) we[e * sps + k] = en;
      if (en) begin
        r = r | (z << (e * ew));
        fl[e * sps] = f;
      end
    end
  endfunction

  task automatic check_now();
    exp_t e;
    e = exp_q.pop_front();
    n_checks++;
    if (out_valid !== e.v || out_result !== e.r || out_wren !== e.we || out_flags !== e.fl) begin
      n_err++;
      $display("FAIL %s: got v=%0b r=%h we=%b fl=%b, expected v=%0b r=%h we=%b fl=%b",
               e.tag, out_valid, out_result, out_wren, out_flags, e.v, e.r, e.we, e.fl);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] w, input logic [2:0] op,
                      input logic [1:0] fm, input logic [63:0] a, input logic [63:0] b,
                      input logic [63:0] s, input logic [3:0] m, input string tag);
    exp_t e;
    @(negedge clk);
    check_now();
    in_valid = v; in_wcode = w; in_op = op; in_form = fm;
    in_a = a; in_b = b; in_scalar = s; in_mask = m;
    e.v = v; e.tag = tag;
    if (v) model(w, op, fm, a, b, s, m, e.r, e.we, e.fl);
    else begin e.r = '0; e.we = '0; e.fl = '0; end
    exp_q.push_back(e);
  endtask

  function automatic string tag_for(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R4";
      3'd2:       return "R6";
      3'd3:       return "R7";
      default:    return "R8";
    endcase
  endfunction

  initial begin
    exp_t e0;
    #1000000;
    if (!done) begin
      n_err++; n_checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    exp_t e0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    e0.v = 1'b0; e0.r = '0; e0.we = '0; e0.fl = '0; e0.tag = "R1";
    exp_q.push_back(e0);

    // R3: per-element carry isolation across widths
    step(1, 2'd0, 3'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, '0, 4'hF, "R3");
    step(1, 2'd1, 3'd0, 2'd0, 64'hFFFF_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, '0, 4'hF, "R3");
    step(1, 2'd2, 3'd0, 2'd0, 64'h0000_FFFF_FFFF_FFFF, 64'h1, '0, 4'h1, "R3");
    step(1, 2'd3, 3'd1, 2'd0, 64'h0, 64'h1, '0, 4'h1, "R3");
    step(1, 2'd0, 3'd1, 2'd0, 64'h0000_0000_0000_0000, 64'h0001_0000_0001_0000, '0, 4'hF, "R3");
    // R4 / R5: modular add and subtract with overflow flags
    step(1, 2'd0, 3'd0, 2'd0, 64'h7FFF_1234_8000_0001, 64'h0001_1111_8000_0002, '0, 4'hF, "R5");
    step(1, 2'd0, 3'd1, 2'd0, 64'h8000_0005_7FFF_0000, 64'h0001_0003_FFFF_0001, '0, 4'hF, "R5");
    step(1, 2'd1, 3'd1, 2'd0, 64'h8000_0000_1234_5678, 64'h0000_0001_0000_0001, '0, 4'hF, "R5");
    step(1, 2'd2, 3'd0, 2'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, '0, 4'h1, "R5");
    step(1, 2'd0, 3'd0, 2'd0, 64'h0102_0304_0506_0708, 64'h1010_2020_3030_4040, '0, 4'hF, "R4");
    // R6: signed saturation at each width
    step(1, 2'd0, 3'd2, 2'd0, 64'h7FFF_8000_0010_7FF0, 64'h0001_8000_0020_0100, '0, 4'hF, "R6");
    step(1, 2'd1, 3'd2, 2'd0, 64'h8000_0000_7FFF_FFFF, 64'hFFFF_FFFF_0000_0001, '0, 4'hF, "R6");
    step(1, 2'd2, 3'd2, 2'd0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, '0, 4'h1, "R6");
    step(1, 2'd2, 3'd2, 2'd0, 64'h7FFF_FFFF_FFFF_FFF0, 64'h20, '0, 4'h1, "R6");
    // R7: unsigned saturation
    step(1, 2'd0, 3'd3, 2'd0, 64'hFFFF_0001_8000_FFF0, 64'h0001_0001_8000_000F, '0, 4'hF, "R7");
    step(1, 2'd1, 3'd3, 2'd0, 64'hFFFF_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, '0, 4'hF, "R7");
    step(1, 2'd2, 3'd3, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, '0, 4'h1, "R7");
    // R8: logic ops and the empty opcode
    step(1, 2'd0, 3'd4, 2'd0, 64'hF0F0_FFFF_1234_0000, 64'hFF00_FFFF_0FF0_FFFF, '0, 4'hF, "R8");
    step(1, 2'd1, 3'd5, 2'd0, 64'hF0F0_0000_1234_0000, 64'h0F0F_0000_0001_0000, '0, 4'hF, "R8");
    step(1, 2'd2, 3'd6, 2'd0, 64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_0000_FFFF_0000, '0, 4'h1, "R8");
    step(1, 2'd0, 3'd7, 2'd0, 64'h7FFF_7FFF_7FFF_7FFF, 64'h1, '0, 4'hF, "R8");
    // R9: operand forms with broadcast scalar
    step(1, 2'd0, 3'd1, 2'd1, 64'h0010_0020_0030_0040, 64'hDEAD, 64'hBEEF_0000_0000_0005, 4'hF, "R9");
    step(1, 2'd0, 3'd1, 2'd2, 64'hDEAD, 64'h0001_0002_0003_0004, 64'h1111_2222_3333_0010, 4'hF, "R9");
    step(1, 2'd1, 3'd1, 2'd2, 64'h0, 64'h0000_0001_0000_0002, 64'hFFFF_FFFF_0000_0100, 4'hF, "R9");
    step(1, 2'd2, 3'd0, 2'd1, 64'h5, 64'h0, 64'h1234_5678_9ABC_DEF0, 4'h1, "R9");
    step(1, 2'd0, 3'd0, 2'd3, 64'h0001_0001_0001_0001, 64'h0002_0002_0002_0002, 64'hFFFF, 4'hF, "R9");
    // R10: masks, including ignored higher mask bits
    step(1, 2'd0, 3'd0, 2'd0, 64'h7FFF_7FFF_7FFF_7FFF, 64'h0001_0001_0001_0001, '0, 4'h5, "R10");
    step(1, 2'd1, 3'd2, 2'd0, 64'h7FFF_FFFF_7FFF_FFFF, 64'h1_0000_0001, '0, 4'hA, "R10");
    step(1, 2'd1, 3'd0, 2'd0, 64'h1111_1111_2222_2222, 64'h1, '0, 4'h4, "R10");
    step(1, 2'd2, 3'd0, 2'd0, 64'h1111_1111_2222_2222, 64'h1, '0, 4'hE, "R10");
    step(1, 2'd0, 3'd3, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0001_0001_0001, '0, 4'h0, "R10");
    // R11: flag reported at lowest slot
    step(1, 2'd1, 3'd0, 2'd0, 64'h7FFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001, '0, 4'hF, "R11");
    step(1, 2'd2, 3'd3, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, '0, 4'h1, "R11");
    // R2: idle gaps
    step(0, 2'd0, 3'd0, 2'd0, 64'h7FFF, 64'h1, '0, 4'hF, "R2");
    step(0, 2'd1, 3'd3, 2'd0, '1, '1, '0, 4'hF, "R2");
    step(1, 2'd0, 3'd0, 2'd0, 64'h1, 64'h1, '0, 4'hF, "R2");

    // Mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      step((n % 7) != 3, 2'($urandom_range(0, 3)), op, 2'($urandom_range(0, 3)),
           {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
           4'($urandom), tag_for(op));
    end

    step(0, 2'd0, 3'd0, 2'd0, '0, '0, '0, 4'h0, "R2");
    @(negedge clk);
    check_now();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule